// File: doc/BRIEF.md
# Rotating-Pattern Pulse Generator

This block turns a 16-bit word into a repeating single-bit waveform. A parallel load on a rising clock edge writes the word into a circular shift register. On every later edge with no load, the register rotates by one place. The output is always the register's top bit. The output therefore steps through the loaded word from bit 15 down to bit 0 and then starts again. No bit is ever dropped.

Because the waveform comes from the stored bits alone, the same logic can divide the clock by 2, 4 or 8. It can also produce any high:low split that fits 8 or 16 clocks, such as 1:7, 1:15, 3:13 or 11:5. There are no counters and no comparators. A new word can be loaded at any time, and it replaces the running sequence on the next edge. A synchronous active-low reset clears the register to all zeros.

Top module: `pulse_pattern_gen`

## Requirements
- R1: While `rst_n` is 0 at a rising edge, the register becomes all zeros, so `pulse_out` is 0 after that edge. Reset wins over `load_en`.
- R2: When `rst_n` is 1 and `load_en` is 1 at a rising edge, the register takes `pattern_in`. After that edge `pulse_out` equals `pattern_in[15]`.
- R3: When `rst_n` is 1 and `load_en` is 0 at a rising edge, the register rotates one place toward the MSB. Bit i moves to bit i+1, and bit 15 wraps into bit 0.
- R4: After a load of word P followed by k rotating edges, `pulse_out` equals P[15 - (k mod 16)]. The output sequence repeats every 16 clocks.
- R5: Loading 16'h5555, 16'h3333 or 16'h0F0F makes `pulse_out` a square wave at 1/2, 1/4 or 1/8 of the clock frequency.
- R6: Loading 16'h8080, 16'h8000, 16'hE000 or 16'hFFE0 gives high:low run lengths of 1:7, 1:15, 3:13 or 11:5 clocks.
- R7: `pulse_out` is registered. A change on `pattern_in` or `load_en` between edges leaves it unchanged.
- R8: A load in the middle of a running sequence takes effect on the very next edge. The old pattern is then discarded.
- R9: A rotation preserves the number of ones held in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear |
| load_en | input | 1 | 1: capture pattern_in at the edge; 0: rotate |
| pattern_in | input | 16 | Waveform word, bit 15 played first |
| pulse_out | output | 1 | Register MSB |

## Verification
The bench builds the block with its default width of 16. This makes every required frequency and duty word representable, and it exposes the wrap from bit 15 to bit 0 once per 16 clocks. Each word runs for at least two full periods, so a rotation that drops or duplicates a bit shows up in the second pass. Reloads are also issued at odd offsets, which shows that a new word always restarts at its own bit 15.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR  = 2'd0,
    OP_LOAD   = 2'd1,
    OP_ROTATE = 2'd2
  } pgen_op_e;
endpackage

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
  import pgen_pkg::*;
(
  input  logic     rst_n,
  input  logic     load_en,
  output pgen_op_e op,
  output logic     load_evt,
  output logic     rot_evt
);
  // reset beats load, load beats rotation
  always_comb begin
    if (!rst_n)       op = OP_CLEAR;
    else if (load_en) op = OP_LOAD;
    else              op = OP_ROTATE;
  end

  assign load_evt = (op == OP_LOAD);
  assign rot_evt  = (op == OP_ROTATE);
endmodule

// File: rtl/pgen_next.sv
module pgen_next
  import pgen_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  pgen_op_e           op,
  input  logic [WIDTH-1:0]   cur,
  input  logic [WIDTH-1:0]   pattern,
  output logic [WIDTH-1:0]   nxt
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] rotated;

  // rotate toward the MSB: each bit takes its lower neighbour, bit 0 takes the MSB
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_rot
      if (b == 0) begin : g_wrap
        assign rotated[b] = cur[TOP];
      end else begin : g_step
        assign rotated[b] = cur[b-1];
      end
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_CLEAR:  nxt = '0;
      OP_LOAD:   nxt = pattern;
      default:   nxt = rotated;
    endcase
  end
endmodule

// File: rtl/pgen_store.sv
module pgen_store #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/pulse_pattern_gen.sv
module pulse_pattern_gen
  import pgen_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] pattern_in,
  output logic             pulse_out
);
  localparam int MSB = WIDTH - 1;

  pgen_op_e         op;
  logic             load_evt;
  logic             rot_evt;
  logic [WIDTH-1:0] shreg_d;
  logic [WIDTH-1:0] shreg_q;

  pgen_ctrl u_ctrl (
    .rst_n    (rst_n),
    .load_en  (load_en),
    .op       (op),
    .load_evt (load_evt),
    .rot_evt  (rot_evt)
  );

  pgen_next #(.WIDTH(WIDTH)) u_next (
    .op      (op),
    .cur     (shreg_q),
    .pattern (pattern_in),
    .nxt     (shreg_d)
  );

  pgen_store #(.WIDTH(WIDTH)) u_store (
    .clk (clk),
    .d   (shreg_d),
    .q   (shreg_q)
  );

  assign pulse_out = shreg_q[MSB];
endmodule

// File: rtl/pgen_chk.sv
module pgen_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_evt,
  input logic             rot_evt,
  input logic [WIDTH-1:0] pattern_in,
  input logic [WIDTH-1:0] shreg,
  input logic             pulse_out
);
  // R1
  clear_chk: assert property (@(posedge clk) !rst_n |=> (shreg == '0) && !pulse_out);

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (shreg == $past(pattern_in)) && (pulse_out == $past(pattern_in[WIDTH-1])));

  // R3
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_evt |=> shreg == {$past(shreg[WIDTH-2:0]), $past(shreg[WIDTH-1])});

  // R4
  walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_evt |=> pulse_out == $past(shreg[WIDTH-2]));

  // R9
  ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_evt |=> $countones(shreg) == $countones($past(shreg)));

  // R2
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_evt, rot_evt}) && (load_evt || rot_evt));
endmodule

bind pulse_pattern_gen pgen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_evt   (load_evt),
  .rot_evt    (rot_evt),
  .pattern_in (pattern_in),
  .shreg      (shreg_q),
  .pulse_out  (pulse_out)
);

// File: tb/test_pulse_pattern_gen.sv
module test_pulse_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [15:0] pattern_in = 16'h0000;
  logic        pulse_out;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  // behavioural model: stored word plus number of rotations since load
  logic [15:0] m_word = 16'h0000;
  int          m_steps = 0;
  bit          m_valid = 1'b0;

  always #4 clk = ~clk;

  pulse_pattern_gen i_pulse_pattern_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .pattern_in (pattern_in),
    .pulse_out  (pulse_out)
  );

  function automatic logic model_bit(logic [15:0] w, int k);
    return w[15 - (k % 16)];
  endfunction

  task automatic check(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: pulse_out=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 16'h0000; m_steps = 0; m_valid = 1'b1;
    end else if (load_en) begin
      m_word = pattern_in; m_steps = 0;
    end else begin
      m_steps = m_steps + 1;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (m_valid) check(cur_req, pulse_out, model_bit(m_word, m_steps));
  end

  task automatic load_word(logic [15:0] w, string req);
    @(negedge clk);
    cur_req = req; load_en = 1'b1; pattern_in = w;
    @(negedge clk);
    load_en = 1'b0;
    pattern_in = ~w;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  // measure high and low run lengths over one period starting at a rising output
  task automatic measure(logic [15:0] w, int exp_hi, int exp_lo, string req);
    int hi = 0;
    int lo = 0;
    int guard = 0;
    load_word(w, req);
    while (!(pulse_out == 1'b1) && guard < 32) begin @(negedge clk); guard++; end
    while (pulse_out == 1'b1 && guard < 64) begin hi++; @(negedge clk); guard++; end
    while (pulse_out == 1'b0 && guard < 96) begin lo++; @(negedge clk); guard++; end
    compared++;
    if (hi != exp_hi || lo != exp_lo) begin
      mismatched++;
      $display("FAIL %s: high/low=%0d/%0d expected %0d/%0d", req, hi, lo, exp_hi, exp_lo);
    end
    run(32);
  endtask

  initial begin
    // R1: reset with load asserted must still clear
    cur_req = "R1"; load_en = 1'b1; pattern_in = 16'hFFFF;
    run(3);
    check("R1", pulse_out, 1'b0);
    load_en = 1'b0;
    rst_n = 1'b1;
    // R2/R4: arbitrary word walked for two periods
    load_word(16'hA5C3, "R2");
    check("R2", pulse_out, 1'b1);
    cur_req = "R4"; run(33);
    // R3: single moving one wraps from MSB into bit 0
    load_word(16'h8000, "R3"); cur_req = "R3"; run(34);
    // R5: clock division
    load_word(16'h5555, "R5"); run(32);
    load_word(16'h3333, "R5"); run(32);
    load_word(16'h0F0F, "R5"); run(32);
    // R6: duty ratios by run length
    measure(16'h8080, 1, 7, "R6");
    measure(16'h8000, 1, 15, "R6");
    measure(16'hE000, 3, 13, "R6");
    measure(16'hFFE0, 11, 5, "R6");
    // R7: input changes between edges do not reach the output
    load_word(16'h7FFF, "R7");
    #1;
    begin
      logic held = pulse_out;
      pattern_in = 16'hFFFF; load_en = 1'b1;
      #2;
      check("R7", pulse_out, held);
      load_en = 1'b0;
    end
    // R8: reload mid-sequence at odd offset
    load_word(16'h00FF, "R8"); run(5);
    load_word(16'hC001, "R8");
    check("R8", pulse_out, 1'b1);
    cur_req = "R8"; run(35);
    // R9: rotation keeps ones; all-ones and all-zeros words stay constant
    load_word(16'hFFFF, "R9"); cur_req = "R9"; run(20);
    load_word(16'h0000, "R9"); run(20);
    // R1: reset mid-run
    cur_req = "R1"; rst_n = 1'b0; run(2); rst_n = 1'b1; run(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 8);
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule